// File: doc/BRIEF.md
# Reloadable Periodic Interrupt Timer

This block generates a repeating interrupt at a rate set by software. It runs on the system clock. A one-cycle enable pulse, `tick_32k`, arrives at 32768 Hz, and the timer counts down by one on each such pulse. To get an interrupt rate of F hertz, software loads a period of 32768 / F ticks and then sets the run bit.

Each time the count expires, the timer reloads itself from the stored period and raises the periodic status bit. That bit sits in the same raw, enable, masked and clear registers as an alarm event, which arrives from outside as a pulse. A single interrupt line is the OR of the two masked bits.

Two rules protect the timer while it runs:
- The period register cannot be rewritten while the timer is running.
- A start or stop opens a busy window that lasts until one 32 kHz tick has passed. The control register rejects writes during that window.

An optional self-start bit lets a period write start the timer directly.

Top module: `ptmr_top`

Byte addresses: 0x10 interrupt enable, 0x14 raw status, 0x18 masked status, 0x1C clear (write 1 to clear), 0x20 current count (read only), 0x24 period, 0x28 control. In all four interrupt registers, bit 1 is the periodic event and bit 0 is the alarm. In the control register, bit 0 is self-start, bit 1 is run and bit 2 is busy (read only). Unmapped addresses read as zero.

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Setting the run bit (control bit 1) from zero loads the count from the period register, and the loaded count is visible at 0x20 on the next cycle.
- R3: While running, each tick decrements a count greater than 1. A tick at count 1 reloads the period and sets raw bit 1, so a period of N gives one event every N ticks.
- R4: A write to the period register (0x24) while the run bit is set leaves both the period and the count unchanged.
- R5: With self-start (control bit 0) set, a period write while stopped stores the value, starts the timer and loads the count with that value. With self-start clear, the same write only stores the value.
- R6: Any change of the run bit sets busy (control bit 2), and the first tick after that clears it. A control write while busy is set has no effect.
- R7: A period of zero leaves a running timer at count zero, and it never sets raw bit 1.
- R8: Clearing the run bit stops the count, and the stopped value stays readable at 0x20 through later ticks.
- R9: The masked status equals raw AND enable. `irq` is high exactly when the masked status is nonzero. An `alarm_evt` pulse sets raw bit 0. Writing ones to 0x1C clears the matching raw bits.
- R10: When an expiry and a clear of raw bit 1 fall in the same cycle, raw bit 1 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable pulse at 32768 Hz |
| alarm_evt | input | 1 | One-cycle alarm event pulse, sets raw bit 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt, OR of masked status bits |

## Verification
Two same-cycle collisions matter most.

The first is an expiry landing on the same clock as a software clear of the periodic status bit. The bench raises a tick on the exact cycle of the clear write, while the count sits at 1. It then checks that the raw bit reads back as set.

The second is a start landing on the same cycle as the busy window closing or a tick arriving. A behavioural reference model steps with every clock, and the bench compares the interrupt line and the read data against it each cycle.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    // Register byte offsets
    localparam logic [7:0] OFF_IEN    = 8'h10;
    localparam logic [7:0] OFF_RAW    = 8'h14;
    localparam logic [7:0] OFF_MASKED = 8'h18;
    localparam logic [7:0] OFF_CLR    = 8'h1C;
    localparam logic [7:0] OFF_COUNT  = 8'h20;
    localparam logic [7:0] OFF_PERIOD = 8'h24;
    localparam logic [7:0] OFF_CTRL   = 8'h28;

    // Event bit positions shared by the four interrupt registers
    localparam int EVT_ALARM  = 0;
    localparam int EVT_PERIOD = 1;
    localparam int N_EVT      = 2;

    // Control register fields, packed so that busy=bit2, run=bit1, autostart=bit0
    typedef struct packed {
        logic busy;
        logic run;
        logic autostart;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic addr_is(input logic [7:0] addr, input logic [7:0] off);
        return addr == off;
    endfunction

endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             period_wr,
    input  logic             wr_autostart,
    input  logic             wr_run,
    input  logic [CNT_W-1:0] wr_period,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] period_q,
    output logic             start,
    output logic [CNT_W-1:0] start_val
);

    logic             nxt_run;
    logic             nxt_auto;
    logic [CNT_W-1:0] nxt_period;
    logic             run_change;

    always_comb begin
        nxt_run    = ctrl_q.run;
        nxt_auto   = ctrl_q.autostart;
        nxt_period = period_q;
        start      = 1'b0;
        start_val  = period_q;
        // Control writes are dropped while the busy window is open
        if (ctrl_wr && !ctrl_q.busy) begin
            nxt_auto = wr_autostart;
            nxt_run  = wr_run;
            if (wr_run && !ctrl_q.run) begin
                start = 1'b1;
            end
        end
        // Period writes are dropped while running
        if (period_wr && !ctrl_q.run) begin
            nxt_period = wr_period;
            if (ctrl_q.autostart) begin
                nxt_run   = 1'b1;
                start     = 1'b1;
                start_val = wr_period;
            end
        end
    end

    assign run_change = (nxt_run != ctrl_q.run);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
        end else begin
            ctrl_q.run       <= nxt_run;
            ctrl_q.autostart <= nxt_auto;
            period_q         <= nxt_period;
            if (run_change) begin
                ctrl_q.busy <= 1'b1;
            end else if (tick) begin
                ctrl_q.busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic advance;

    assign advance = run && tick && !start && (count != '0);
    assign expire  = advance && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (start) begin
            count <= start_val;
        end else if (advance) begin
            count <= (count == ONE) ? period : count - ONE;
        end
    end

endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic         clr_wr,
    input  logic         ien_wr,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] raw,
    output logic [N-1:0] ien,
    output logic [N-1:0] masked,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_evt
        always_ff @(posedge clk) begin
            if (rst) begin
                raw[i] <= 1'b0;
                ien[i] <= 1'b0;
            end else begin
                // a new event wins over a same-cycle clear
                if (set_evt[i]) begin
                    raw[i] <= 1'b1;
                end else if (clr_wr && wr_bits[i]) begin
                    raw[i] <= 1'b0;
                end
                if (ien_wr) begin
                    ien[i] <= wr_bits[i];
                end
            end
        end
        assign masked[i] = raw[i] & ien[i];
    end

    assign irq = |masked;

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic              alarm_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [7:0]       a8;
    logic             hit_ctrl, hit_period, hit_clr, hit_ien;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] count;
    logic             start;
    logic [CNT_W-1:0] start_val;
    logic             expire;
    logic [N_EVT-1:0] raw, ien, masked, set_evt;
    logic             unused_bus;

    assign a8         = reg_addr[7:0];
    assign hit_ctrl   = reg_wr && addr_is(a8, OFF_CTRL);
    assign hit_period = reg_wr && addr_is(a8, OFF_PERIOD);
    assign hit_clr    = reg_wr && addr_is(a8, OFF_CLR);
    assign hit_ien    = reg_wr && addr_is(a8, OFF_IEN);
    assign unused_bus = ^{reg_wdata, reg_addr};

    ptmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_32k),
        .ctrl_wr      (hit_ctrl),
        .period_wr    (hit_period),
        .wr_autostart (reg_wdata[0]),
        .wr_run       (reg_wdata[1]),
        .wr_period    (reg_wdata[CNT_W-1:0]),
        .ctrl_q       (ctrl),
        .period_q     (period),
        .start        (start),
        .start_val    (start_val)
    );

    ptmr_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_32k),
        .run       (ctrl.run),
        .start     (start),
        .start_val (start_val),
        .period    (period),
        .count     (count),
        .expire    (expire)
    );

    always_comb begin
        set_evt             = '0;
        set_evt[EVT_ALARM]  = alarm_evt;
        set_evt[EVT_PERIOD] = expire;
    end

    ptmr_irq #(.N(N_EVT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .clr_wr  (hit_clr),
        .ien_wr  (hit_ien),
        .wr_bits (reg_wdata[N_EVT-1:0]),
        .raw     (raw),
        .ien     (ien),
        .masked  (masked),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[ADDR_W-1:0] == ADDR_W'(a8)) begin
            unique case (a8)
                OFF_IEN:    reg_rdata = DATA_W'(ien);
                OFF_RAW:    reg_rdata = DATA_W'(raw);
                OFF_MASKED: reg_rdata = DATA_W'(masked);
                OFF_COUNT:  reg_rdata = DATA_W'(count);
                OFF_PERIOD: reg_rdata = DATA_W'(period);
                OFF_CTRL:   reg_rdata = DATA_W'(ctrl);
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ptmr_checks.sv
module ptmr_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             busy,
    input logic             hit_ctrl,
    input logic             hit_period,
    input logic             start,
    input logic             expire,
    input logic             raw_per,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period
);

    // R4: a period write while running changes nothing
    p_period_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (run && hit_period) |=> $stable(period));

    // R6: a change of run opens the busy window
    p_busy_on_change_r6: assert property (@(posedge clk) disable iff (rst)
        (run != $past(run)) |-> busy);

    // R6: control writes inside the busy window do not move run
    p_ctrl_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_ctrl && busy) |=> $stable(run));

    // R3: while running the count never exceeds the period
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (count <= period));

    // R3: an expiry is recorded in raw bit 1
    p_expire_sets_raw_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw_per);

    // R7: a zero period never expires
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (run && period == '0) |-> !expire);

    // R8: a stopped timer holds its count
    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(count));

endmodule

bind ptmr_top ptmr_checks #(.CNT_W(CNT_W)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl.run),
    .busy       (ctrl.busy),
    .hit_ctrl   (hit_ctrl),
    .hit_period (hit_period),
    .start      (start),
    .expire     (expire),
    .raw_per    (raw[1]),
    .count      (count),
    .period     (period)
);

// File: tb/test_ptmr_top.sv
module test_ptmr_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_32k = 1'b0;
    logic        alarm_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    ptmr_top i_ptmr_top (
        .clk       (clk),
        .rst       (rst),
        .tick_32k  (tick_32k),
        .alarm_evt (alarm_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_run, m_auto, m_busy;
    int unsigned m_period, m_count;
    bit [1:0]    m_raw, m_ien;

    function automatic int unsigned model_read(input logic [7:0] a);
        case (a)
            8'h10:   return m_ien;
            8'h14:   return m_raw;
            8'h18:   return m_raw & m_ien;
            8'h20:   return m_count;
            8'h24:   return m_period;
            8'h28:   return {m_busy, m_run, m_auto};
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit          go, n_run, fired;
        int unsigned go_val;
        if (rst) begin
            m_run = 0; m_auto = 0; m_busy = 0;
            m_period = 0; m_count = 0; m_raw = 0; m_ien = 0;
        end else begin
            go = 0; fired = 0; n_run = m_run; go_val = m_period;
            if (reg_wr && reg_addr == 8'h28 && !m_busy) begin
                if (reg_wdata[1] && !m_run) go = 1;
                n_run  = reg_wdata[1];
                m_auto = reg_wdata[0];
            end
            if (reg_wr && reg_addr == 8'h24 && !m_run) begin
                m_period = reg_wdata[15:0];
                if (m_auto) begin
                    n_run = 1; go = 1; go_val = reg_wdata[15:0];
                end
            end
            if (go) m_count = go_val;
            else if (m_run && tick_32k && m_count > 0) begin
                if (m_count == 1) begin
                    m_count = m_period; fired = 1;
                end else m_count--;
            end
            if (n_run != m_run) m_busy = 1;
            else if (tick_32k) m_busy = 0;
            m_run = n_run;
            if (reg_wr && reg_addr == 8'h1C) m_raw = m_raw & ~reg_wdata[1:0];
            if (fired) m_raw[1] = 1;
            if (alarm_evt) m_raw[0] = 1;
            if (reg_wr && reg_addr == 8'h10) m_ien = reg_wdata[1:0];
        end
    end

    // Per-cycle comparison against the model, before inputs move
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks += 2;
            if (irq !== (|(m_raw & m_ien))) begin
                errors++;
                $display("FAIL %s (R9 cycle) irq actual=%0b expected=%0b", cur_tag, irq, |(m_raw & m_ien));
            end
            if (reg_rdata !== model_read(reg_addr)) begin
                errors++;
                $display("FAIL %s (cycle) addr=%h rdata actual=%0h expected=%0h",
                         cur_tag, reg_addr, reg_rdata, model_read(reg_addr));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit tk, input bit al);
        @(negedge clk);
        #1;
        reg_wr = w; reg_addr = a; reg_wdata = d; tick_32k = tk; alarm_evt = al;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, reg_addr, 0, 1, 0);
            cyc(0, reg_addr, 0, 0, 0);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cur_tag = tag;
        cyc(0, a, 0, 0, 0);
        #2;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        #2;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        #1 rst = 0;

        // R1: reset values
        rd(8'h10, 0, "R1"); rd(8'h14, 0, "R1"); rd(8'h18, 0, "R1");
        rd(8'h20, 0, "R1"); rd(8'h24, 0, "R1"); rd(8'h28, 0, "R1");
        chk_irq(0, "R1");

        // R2: start loads the period
        cur_tag = "R2";
        wr(8'h10, 2); wr(8'h24, 4); wr(8'h28, 2);
        rd(8'h20, 4, "R2");
        rd(8'h28, 6, "R6");           // busy set after start

        // R3/R6: first tick closes busy and decrements
        tk(1);
        rd(8'h28, 2, "R6");
        rd(8'h20, 3, "R3");
        tk(2);
        rd(8'h20, 1, "R3");
        rd(8'h14, 0, "R3");
        tk(1);
        rd(8'h20, 4, "R3");
        rd(8'h14, 2, "R3");
        rd(8'h18, 2, "R9");
        chk_irq(1, "R9");

        // R4: period write while running ignored
        cur_tag = "R4";
        wr(8'h24, 9);
        rd(8'h24, 4, "R4");
        rd(8'h20, 4, "R4");

        // R9: clear
        wr(8'h1C, 2);
        rd(8'h14, 0, "R9");
        chk_irq(0, "R9");

        // R10: expiry and clear in the same cycle
        tk(3);
        rd(8'h20, 1, "R10");
        cur_tag = "R10";
        cyc(1, 8'h1C, 2, 1, 0);
        rd(8'h14, 2, "R10");
        rd(8'h20, 4, "R10");

        // R8/R6: stop, then a control write during busy is dropped
        tk(1);
        cur_tag = "R6";
        wr(8'h28, 0);
        wr(8'h28, 2);
        rd(8'h28, 4, "R6");
        tk(2);
        rd(8'h20, 3, "R8");
        rd(8'h28, 0, "R8");

        // R5: self-start via period write
        cur_tag = "R5";
        wr(8'h28, 1);
        rd(8'h28, 1, "R5");
        wr(8'h1C, 3);
        wr(8'h24, 3);
        rd(8'h28, 7, "R5");
        rd(8'h20, 3, "R5");
        rd(8'h24, 3, "R5");
        tk(3);
        rd(8'h14, 2, "R5");
        rd(8'h20, 3, "R5");

        // R5: with self-start clear, a period write only stores
        wr(8'h28, 0);
        tk(1);
        wr(8'h24, 5);
        rd(8'h28, 0, "R5");
        rd(8'h24, 5, "R5");
        rd(8'h20, 3, "R5");

        // R7: zero period
        cur_tag = "R7";
        wr(8'h24, 0);
        wr(8'h1C, 3);
        wr(8'h28, 2);
        tk(6);
        rd(8'h14, 0, "R7");
        rd(8'h20, 0, "R7");
        rd(8'h28, 2, "R7");

        // R9: alarm event and masking
        cur_tag = "R9";
        cyc(0, 8'h14, 0, 0, 1);
        rd(8'h14, 1, "R9");
        rd(8'h18, 0, "R9");
        chk_irq(0, "R9");
        wr(8'h10, 3);
        rd(8'h18, 1, "R9");
        chk_irq(1, "R9");
        wr(8'h1C, 1);
        rd(8'h14, 0, "R9");
        chk_irq(0, "R9");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule